// File: doc/BRIEF.md
# ADC conversion timing and flag controller

This block is the digital sequencing half of a successive-approximation analog-to-digital converter. It decides when a conversion begins and how long it lasts. It also decides when the end-of-conversion flag goes high. The analog core is replaced by a state counter that stands in for its duration, and by a stub that supplies a result word.

A conversion can begin in two ways. Software can start it with a start bit while trigger operation is off. When trigger operation is on and the start bit is set, a pulse on either of two trigger group inputs starts it. The duration is a whole number of conversion states. The state length comes from a selectable division of the peripheral clock.

In two-channel scan mode with trigger operation on, a flag-control bit can make the flag wait until one conversion from each trigger group has completed, in either order. Software reads the control fields back through the same register port. It clears the flag with a dedicated input.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_flag` and `result` are 0, and `ctl_rdata` reads 0.
- R2: The clock-select field `ctl_wdata[5:4]` sets the length of one conversion state in peripheral clocks: 00 gives 4, 01 gives 3, 10 gives 2 and 11 gives 1.
- R3: The state-control bit `ctl_wdata[6]` sets the state count: 0 selects 50 states and 1 selects 64. `busy` rises on the edge that accepts a start and stays high for exactly (clocks per state) x (state count) peripheral clocks.
- R4: Bit 0 is the start bit and bit 1 is the trigger enable.
  - With the trigger enable at 0, writing the start bit from 0 to 1 starts a conversion, and the start bit reads back 0 once the conversion ends.
  - With the trigger enable and the start bit both at 1, a high level on `trig0` or `trig1` while `busy` is 0 starts a conversion. Triggers that arrive while `busy` is 1 are dropped. When both trigger inputs are high together, group 0 wins.
- R5: Outside the paired condition of R6, `conv_flag` rises on the edge that ends every conversion. This holds in all modes other than two-channel scan (mode field `ctl_wdata[3:2]` = 01), whatever the value of the flag-control bit `ctl_wdata[7]`.
- R6: The paired condition is trigger enable = 1, mode = 01 and flag-control = 1. Under it, `conv_flag` rises only when conversions from both group 0 and group 1 have completed, in either order.
  - The record of completed groups is cleared when the flag sets, when the start bit goes to 0, or when the mode changes.
- R7: Writes to bits 7:1 take effect only while the start bit reads 0. While it reads 1, those bits keep their value and only the start bit is written.
- R8: Bit 8 and all bits above it always read 0, and writing 1s to them has no effect.
- R9: `conv_flag` stays high until `flag_clr` is sampled high. A flag-set event on the same edge as `flag_clr` wins, and the flag stays high.
- R10: On the edge that ends a conversion, `result` loads a new word. Bit 9 holds the group that started the conversion (0 for a software start). Bits 8:0 hold the number of conversions completed before it, modulo 512. At all other times `result` holds its value.
- R11: Writing the start bit to 0 during a conversion aborts it. `busy` is 0 after the next edge, and that conversion neither sets the flag nor updates `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read data |
| trig0 | input | 1 | Group 0 conversion trigger |
| trig1 | input | 1 | Group 1 conversion trigger |
| flag_clr | input | 1 | Clears the completion flag |
| busy | output | 1 | High while a conversion is timed |
| conv_flag | output | 1 | End-of-conversion flag |
| result | output | 10 | Latched stub result word |

## Verification
The assertions assume the following about the inputs:
- Every input is synchronous to `clk`.
- A start can only occur while `busy` is low, so the start and end of a conversion never fall on the same edge.
- A write that clears the start bit is the only way a conversion ends early.

The stimulus drives inputs on the falling edge and holds triggers for one cycle. It waits for `busy` to fall before it expects a new conversion, except where it deliberately sends a trigger or a locked write into a busy conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // bit positions inside the control word
  localparam int B_START = 0;
  localparam int CFG_LO  = 1;
  localparam int CFG_HI  = 7;
  localparam int CFG_W   = CFG_HI - CFG_LO + 1;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SCAN2  = 2'b01,
    MODE_SCAN4  = 2'b10,
    MODE_SCAN8  = 2'b11
  } scan_mode_e;

  // packed so that bit 0 maps to control bit 1, bit 6 to control bit 7
  typedef struct packed {
    logic       fctl;
    logic       stc;
    logic [1:0] cks;
    scan_mode_e mode;
    logic       trgen;
  } cfg_t;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] cks,
  output logic       tick
);

  logic [1:0] div_q;
  logic [1:0] div_n;
  logic [1:0] lim;

  // 00 -> every 4th clock, 01 -> 3rd, 10 -> 2nd, 11 -> every clock
  assign lim  = 2'd3 - cks;
  assign tick = run & (div_q == lim);

  always_comb begin
    div_n = div_q;
    if (restart) begin
      div_n = 2'd0;
    end else if (run) begin
      div_n = tick ? 2'd0 : div_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 2'd0;
    end else begin
      div_q <= div_n;
    end
  end

endmodule

// File: rtl/adc_state_timer.sv
module adc_state_timer #(
  parameter int ST_SHORT = 50,
  parameter int ST_LONG  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic abort,
  input  logic tick,
  input  logic stc,
  output logic busy,
  output logic done
);

  localparam int ST_W = $clog2(ST_LONG);
  localparam logic [ST_W-1:0] LAST_SHORT = ST_W'(ST_SHORT - 1);
  localparam logic [ST_W-1:0] LAST_LONG  = ST_W'(ST_LONG - 1);

  logic [ST_W-1:0] st_q, st_n;
  logic            busy_q, busy_n;
  logic [ST_W-1:0] last;

  assign last = stc ? LAST_LONG : LAST_SHORT;
  assign done = busy_q & tick & (st_q == last) & ~abort;
  assign busy = busy_q;

  always_comb begin
    st_n   = st_q;
    busy_n = busy_q;
    if (abort) begin
      busy_n = 1'b0;
    end else if (go) begin
      busy_n = 1'b1;
      st_n   = '0;
    end else if (done) begin
      busy_n = 1'b0;
    end else if (busy_q && tick) begin
      st_n = st_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      busy_q <= busy_n;
    end
  end

endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic grp,
  input  logic pair,
  input  logic pend_clr,
  input  logic flag_clr,
  output logic flag
);

  logic [1:0] pend_q, pend_n;
  logic       flag_q, flag_n;
  logic       other_done;
  logic       flag_set;

  assign other_done = grp ? pend_q[0] : pend_q[1];
  assign flag_set   = done & (~pair | other_done);
  assign flag       = flag_q;

  always_comb begin
    pend_n = pend_q;
    if (flag_set || pend_clr) begin
      pend_n = 2'b00;
    end else if (done && pair) begin
      pend_n[grp] = 1'b1;
    end
    flag_n = flag_set | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 2'b00;
      flag_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      flag_q <= flag_n;
    end
  end

endmodule

// File: rtl/adc_result_stub.sv
module adc_result_stub #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             grp,
  output logic [RES_W-1:0] sample
);

  localparam int CNT_W = RES_W - 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign sample = {grp, cnt_q};

  always_comb begin
    cnt_n = cnt_q;
    if (done) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CTL_W    = 16,
  parameter int RES_W    = 10,
  parameter int ST_SHORT = 50,
  parameter int ST_LONG  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             trig0,
  input  logic             trig1,
  input  logic             flag_clr,
  output logic             busy,
  output logic             conv_flag,
  output logic [RES_W-1:0] result
);

  localparam int PAD_W = CTL_W - CFG_HI - 1;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe[1];

  // control state
  logic             start_q, start_n;
  cfg_t             cfg_q, cfg_n;
  logic             grp_q, grp_n;
  logic [RES_W-1:0] res_q, res_n;

  logic             wr_start;
  cfg_t             wr_cfg;
  logic             abort, sw_go, trig_go, go, go_grp;
  logic             busy_i, tick, conv_done, pair, pend_clr;
  logic [RES_W-1:0] stub_sample;
  logic             unused_hi;

  assign wr_start  = ctl_wdata[B_START];
  assign wr_cfg    = cfg_t'(ctl_wdata[CFG_HI:CFG_LO]);
  assign unused_hi = ^ctl_wdata[CTL_W-1:CFG_HI+1];

  assign abort   = ctl_we & start_q & ~wr_start;
  assign sw_go   = ctl_we & ~start_q & wr_start & ~wr_cfg.trgen;
  assign trig_go = start_q & cfg_q.trgen & ~busy_i & (trig0 | trig1) & ~abort;
  assign go      = sw_go | trig_go;
  assign go_grp  = trig_go & ~trig0;
  assign pair    = cfg_q.trgen & (cfg_q.mode == MODE_SCAN2) & cfg_q.fctl;

  always_comb begin
    start_n = start_q;
    cfg_n   = cfg_q;
    grp_n   = grp_q;
    res_n   = res_q;
    if (ctl_we) begin
      start_n = wr_start;
      if (!start_q) begin
        cfg_n = wr_cfg;
      end
    end else if (conv_done && !cfg_q.trgen) begin
      start_n = 1'b0;
    end
    if (go) begin
      grp_n = go_grp;
    end
    if (conv_done) begin
      res_n = stub_sample;
    end
  end

  assign pend_clr = (start_q & ~start_n) | (cfg_n.mode != cfg_q.mode);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      start_q <= 1'b0;
      cfg_q   <= '0;
      grp_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      start_q <= start_n;
      cfg_q   <= cfg_n;
      grp_q   <= grp_n;
      res_q   <= res_n;
    end
  end

  adc_clk_div u_div (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .restart (go),
    .run     (busy_i),
    .cks     (cfg_q.cks),
    .tick    (tick)
  );

  adc_state_timer #(
    .ST_SHORT (ST_SHORT),
    .ST_LONG  (ST_LONG)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n_i),
    .go    (go),
    .abort (abort),
    .tick  (tick),
    .stc   (cfg_q.stc),
    .busy  (busy_i),
    .done  (conv_done)
  );

  adc_flag_ctrl u_flag (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .done     (conv_done),
    .grp      (grp_q),
    .pair     (pair),
    .pend_clr (pend_clr),
    .flag_clr (flag_clr),
    .flag     (conv_flag)
  );

  adc_result_stub #(
    .RES_W (RES_W)
  ) u_stub (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .done   (conv_done),
    .grp    (grp_q),
    .sample (stub_sample)
  );

  assign busy      = busy_i;
  assign result    = res_q;
  assign ctl_rdata = {{PAD_W{1'b0}}, cfg_q, start_q};

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CTL_W = 16,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             trig0,
  input logic             trig1,
  input logic             flag_clr,
  input logic             busy,
  input logic             conv_flag,
  input logic [RES_W-1:0] result
);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_flag && !flag_clr |=> conv_flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_flag && flag_clr && !busy |=> !conv_flag);

  // R5
  flag_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_flag) |-> $fell(busy));

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_we || trig0 || trig1));

  // R7
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] && ctl_we |=> ctl_rdata[7:1] == $past(ctl_rdata[7:1]));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_we && !ctl_wdata[0] |=> !busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(result));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CTL_W(CTL_W), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .trig0     (trig0),
  .trig1     (trig1),
  .flag_clr  (flag_clr),
  .busy      (busy),
  .conv_flag (conv_flag),
  .result    (result)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wd = 16'h0;
  logic        t0 = 1'b0;
  logic        t1 = 1'b0;
  logic        fclr = 1'b0;
  logic [15:0] rdata;
  logic        busy, conv_flag;
  logic [9:0]  result;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (we),
    .ctl_wdata (wd),
    .ctl_rdata (rdata),
    .trig0     (t0),
    .trig1     (t1),
    .flag_clr  (fclr),
    .busy      (busy),
    .conv_flag (conv_flag),
    .result    (result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_start, m_busy, m_grp, m_flag;
  bit [6:0] m_ctl, n_ctl;
  bit [1:0] m_p;
  int       m_rem, m_cnt, m_res;
  bit       x_abort, x_sw, x_tg, x_done, x_pair, x_set, n_start;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_ctl = 0; m_busy = 0; m_rem = 0; m_grp = 0;
      m_p = 0; m_flag = 0; m_cnt = 0; m_res = 0;
    end else begin
      x_abort = we && m_start && !wd[0];
      x_sw    = we && !m_start && wd[0] && !wd[1];
      x_tg    = m_start && m_ctl[0] && !m_busy && (t0 || t1) && !x_abort;
      x_done  = m_busy && m_rem == 1 && !x_abort;
      x_pair  = m_ctl[0] && m_ctl[2:1] == 2'b01 && m_ctl[6];
      x_set   = x_done && (!x_pair || (m_grp ? m_p[0] : m_p[1]));
      n_start = m_start;
      n_ctl   = m_ctl;
      if (we) begin
        n_start = wd[0];
        if (!m_start) n_ctl = wd[7:1];
      end else if (x_done && !m_ctl[0]) begin
        n_start = 0;
      end
      if (x_set || (m_start && !n_start) || n_ctl[2:1] != m_ctl[2:1]) m_p = 0;
      else if (x_done && x_pair) m_p[m_grp] = 1;
      if (x_done) begin
        m_res = (int'(m_grp) << 9) | (m_cnt % 512);
        m_cnt++;
      end
      m_flag = x_set ? 1'b1 : (fclr ? 1'b0 : m_flag);
      if (x_abort) begin
        m_busy = 0; m_rem = 0;
      end else if (x_sw || x_tg) begin
        m_busy = 1;
        m_rem  = (4 - int'(n_ctl[4:3])) * (n_ctl[5] ? 64 : 50);
        m_grp  = x_tg && !t0;
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) m_busy = 0;
      end
      m_start = n_start;
      m_ctl   = n_ctl;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(busy === m_busy, "R3 busy vs model", busy, m_busy);
      chk(conv_flag === m_flag, "R9 flag vs model", conv_flag, m_flag);
      chk(rdata === {8'h00, m_ctl, m_start}, "R7 rdata vs model", rdata, {m_ctl, m_start});
      chk(result === m_res[9:0], "R10 result vs model", result, m_res);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [15:0] cw(input bit tr, input bit [1:0] md, input bit [1:0] ck,
                                     input bit st, input bit fc, input bit go);
    return {8'h00, fc, st, ck, md, tr, go};
  endfunction

  task automatic wr(input logic [15:0] v);
    we = 1'b1; wd = v;
    @(negedge clk);
    we = 1'b0; wd = 16'h0;
  endtask

  task automatic trg(input bit g);
    if (g) t1 = 1'b1; else t0 = 1'b1;
    @(negedge clk);
    t0 = 1'b0; t1 = 1'b0;
  endtask

  task automatic clrf();
    fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(busy == 0 && conv_flag == 0, "R1 reset outputs", {busy, conv_flag}, 0);
    chk(rdata == 0 && result == 0, "R1 reset rdata/result", rdata, 0);

    // R2 and R3: all eight duration combinations, software start
    for (int ck = 0; ck < 4; ck++) begin
      for (int st = 0; st < 2; st++) begin
        wr(cw(0, 2'b00, ck[1:0], st[0], 0, 1));
        cnt = 0;
        while (busy && cnt < 5000) begin cnt++; @(negedge clk); end
        chk(cnt == (4 - ck) * (st ? 64 : 50), "R2 R3 conversion duration", cnt, (4 - ck) * (st ? 64 : 50));
        chk(rdata[0] == 0, "R4 start bit cleared after software conversion", rdata[0], 0);
        chk(conv_flag == 1, "R5 flag after software conversion", conv_flag, 1);
        chk(result[9] == 0, "R10 software group bit", result[9], 0);
        clrf();
        chk(conv_flag == 0, "R9 flag cleared", conv_flag, 0);
      end
    end

    // R6: paired flag, group 0 then group 1
    wr(cw(1, 2'b01, 2'b11, 0, 1, 1));
    trg(0); wait_idle();
    chk(conv_flag == 0, "R6 flag waits for group 1", conv_flag, 0);
    chk(result[9] == 0, "R10 group 0 tag", result[9], 0);
    trg(1); wait_idle();
    chk(conv_flag == 1, "R6 flag after both (0 then 1)", conv_flag, 1);
    chk(result[9] == 1, "R10 group 1 tag", result[9], 1);
    clrf();
    // R6: group 1 then group 0
    trg(1); wait_idle();
    chk(conv_flag == 0, "R6 flag waits for group 0", conv_flag, 0);
    trg(0); wait_idle();
    chk(conv_flag == 1, "R6 flag after both (1 then 0)", conv_flag, 1);
    clrf();

    // R4: trigger during busy dropped; R7: locked write
    trg(0);
    repeat (3) @(negedge clk);
    t1 = 1'b1; @(negedge clk); t1 = 1'b0;
    wr(cw(0, 2'b10, 2'b00, 1, 0, 1));
    chk(rdata[7:0] == cw(1, 2'b01, 2'b11, 0, 1, 1), "R7 fields locked while start=1", rdata[7:0], cw(1, 2'b01, 2'b11, 0, 1, 1));
    wait_idle();
    chk(conv_flag == 0, "R4 busy trigger dropped", conv_flag, 0);
    // R6 pending cleared by start going 0
    wr(cw(1, 2'b01, 2'b11, 0, 1, 0));
    wr(cw(1, 2'b01, 2'b11, 0, 1, 1));
    trg(1); wait_idle();
    chk(conv_flag == 0, "R6 record cleared by start=0", conv_flag, 0);
    trg(0); wait_idle();
    chk(conv_flag == 1, "R6 flag after fresh pair", conv_flag, 1);
    clrf();

    // R11: abort
    trg(1);
    repeat (5) @(negedge clk);
    wr(cw(1, 2'b01, 2'b11, 0, 1, 0));
    chk(busy == 0, "R11 abort drops busy", busy, 0);
    repeat (60) @(negedge clk);
    chk(conv_flag == 0, "R11 aborted conversion no flag", conv_flag, 0);

    // R8: reserved and upper bits
    wr(16'hFF00 | cw(1, 2'b01, 2'b11, 0, 0, 0));
    chk(rdata[15:8] == 0, "R8 reserved bits read 0", rdata[15:8], 0);

    // R5: mode 01 with flag-control 0, then mode 10 with flag-control 1
    wr(cw(1, 2'b01, 2'b11, 0, 0, 1));
    trg(1); wait_idle();
    chk(conv_flag == 1, "R5 two-channel, flag-control 0", conv_flag, 1);
    clrf();
    wr(cw(1, 2'b01, 2'b11, 0, 0, 0));
    wr(cw(1, 2'b10, 2'b11, 0, 1, 1));
    trg(1); wait_idle();
    chk(conv_flag == 1, "R5 four-channel ignores flag-control", conv_flag, 1);

    // R4: simultaneous triggers, group 0 wins
    clrf();
    t0 = 1'b1; t1 = 1'b1; @(negedge clk); t0 = 1'b0; t1 = 1'b0;
    wait_idle();
    chk(result[9] == 0, "R4 group 0 wins on tie", result[9], 0);

    // R9: set beats clear on the same edge (flag already high here)
    fclr = 1'b1;
    trg(0);
    fclr = 1'b1;
    wait_idle();
    chk(conv_flag == 1, "R9 set wins over clear", conv_flag, 1);
    @(negedge clk);
    fclr = 1'b0;
    chk(conv_flag == 0, "R9 clear after set", conv_flag, 0);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule